// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block gathers up to 32 interrupt request lines and drives two requests toward a processor. One is a normal interrupt and the other is a fast interrupt. Each source has a small configuration word with three fields: a 5-bit priority, an edge or level trigger choice, and a routing bit that sends the source to the fast output. A per-source mask register blocks sources individually. A global mask register silences both outputs at once.

When an output is free, the block picks a winner from the unmasked pending sources routed to that output. It then holds that winner, and keeps the output raised, until software writes an acknowledge for that output to the control register. Software reads the held source numbers from a source-number register. Two or more instances can be chained: the output of a second-level instance feeds one request line of the first. Only the first-level instance enables fast-interrupt routing, through the `FIQ_EN` parameter.

Registers are reached through a synchronous word-addressed port. Writes take effect on the clock edge on which they are presented. Read data appears one cycle after the address.

Top module: `intc_bank`

## Requirements
- R1: After reset, every mask bit reads 1, the global mask reads 1, every configuration word reads 0, both outputs are low, and the source-number register reads 0.
- R2: A source whose mask bit (word 1, bit i) is 1 never raises an output. Clearing that bit to 0 lets the source through.
- R3: A level-mode source requests while its input is high. If the input is still high after its acknowledge, it is chosen again one cycle later. If the input is low, it is not chosen again.
- R4: An edge-mode source (configuration bit 1 = 1) latches a pending request on a rising input. Its acknowledge clears that pending request, and an input that stays high does not request again.
- R5: Among the eligible sources of one output, the lowest priority value (configuration bits 6:2) wins, and on a tie the lowest source index wins. The source-number register (word 2) reports the normal winner in bits 4:0 with an active flag in bit 7, and the fast winner in bits 12:8 with an active flag in bit 15.
- R6: While an output is held, the reported source stays fixed even if a more urgent source arrives.
- R7: Writing control word 3 with bit 0 set releases the normal output, and with bit 1 set releases the fast output. Each output goes low the cycle after the write, and a write of 3 releases both. A release of one output leaves the other output held.
- R8: Configuration bit 0 routes a source to the fast output only when `FIQ_EN` is 1. Otherwise the source goes to the normal output and bit 0 reads back 0.
- R9: Word 0 reads the current request of each source. A write to word 0 is ANDed into the edge pending latches, so writing 0 clears them all.
- R10: While the global mask (word 4, bit 0) is 1, both outputs are low. Writing 0 to it lets held requests out.
- R11: Register reads return the addressed word one clock after the address is presented. Configuration words sit at word 32 + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt request lines, synchronous to clk |
| reg_addr_i | input | 6 | Register word address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The arbitration is driven with a table of request patterns against a fixed priority assignment in which every source has a distinct priority. The patterns cover:
- a single low source and a single high source, which show that the index is decoded;
- sets where the most urgent source is neither the lowest nor the highest index, which separates priority order from index order;
- all sources at once, and an empty pattern.

Directed cases then cover:
- two sources with the same priority, which separates the tie rule from a scan that keeps the last match;
- edge versus level behaviour under a line that stays high;
- a late urgent arrival while a winner is held;
- one-sided and two-sided acknowledges;
- fast routing on a first-level instance and on a second-level instance.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int PRIO_W   = 5;
   localparam int ADDR_W   = 6;
   localparam int CFG_BASE = 32;

   localparam logic [ADDR_W-1:0] A_PEND   = 6'd0;
   localparam logic [ADDR_W-1:0] A_MASK   = 6'd1;
   localparam logic [ADDR_W-1:0] A_SRCNUM = 6'd2;
   localparam logic [ADDR_W-1:0] A_CTRL   = 6'd3;
   localparam logic [ADDR_W-1:0] A_GMASK  = 6'd4;

   // configuration word, LSB first: route-to-fast, edge mode, priority
   typedef struct packed {
      logic [PRIO_W-1:0] prio;
      logic              edge_mode;
      logic              to_fast;
   } src_cfg_t;
endpackage

// File: rtl/intc_trig_capture.sv
module intc_trig_capture #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] edge_mode_i,
   input  logic               pend_wr_i,
   input  logic [NUM_SRC-1:0] pend_wdata_i,
   input  logic [NUM_SRC-1:0] ack_clr_i,
   output logic [NUM_SRC-1:0] req_o
);
   logic [NUM_SRC-1:0] prev_q, pend_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic rise, keep;
      assign rise = src_i[i] & ~prev_q[i];
      assign keep = ~ack_clr_i[i] & (~pend_wr_i | pend_wdata_i[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[i] <= 1'b0;
            pend_q[i] <= 1'b0;
         end else begin
            prev_q[i] <= src_i[i];
            pend_q[i] <= edge_mode_i[i] & ((pend_q[i] & keep) | rise);
         end
      end

      assign req_o[i] = edge_mode_i[i] ? pend_q[i] : src_i[i];
   end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 5,
   localparam int ID_W   = $clog2(NUM_SRC)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             cand_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic                           valid_o,
   output logic [ID_W-1:0]                idx_o
);
   logic [PRIO_W-1:0] best;

   // strict less-than keeps the earliest index on equal priority
   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      best    = '1;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (cand_i[i] && (!valid_o || prio_i[i] < best)) begin
            valid_o = 1'b1;
            idx_o   = ID_W'(i);
            best    = prio_i[i];
         end
      end
   end

   // R5
   pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> cand_i[idx_o]);
endmodule

// File: rtl/intc_out_hold.sv
module intc_out_hold #(
   parameter int NUM_SRC = 32,
   localparam int ID_W   = $clog2(NUM_SRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pick_v_i,
   input  logic [ID_W-1:0] pick_idx_i,
   input  logic            ack_i,
   output logic            held_v_o,
   output logic [ID_W-1:0] held_idx_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_v_o   <= 1'b0;
         held_idx_o <= '0;
      end else if (ack_i) begin
         held_v_o   <= 1'b0;
      end else if (!held_v_o && pick_v_i) begin
         held_v_o   <= 1'b1;
         held_idx_o <= pick_idx_i;
      end
   end

   // R6
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held_v_o && !ack_i) |=> (held_v_o && $stable(held_idx_o)));
endmodule

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter bit FIQ_EN  = 1'b1,
   localparam int ID_W   = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic               reg_we_i,
   input  logic [31:0]        reg_wdata_i,
   output logic [31:0]        reg_rdata_o,
   output logic               irq_o,
   output logic               fiq_o
);
   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_num
      $error("intc_bank: NUM_SRC must lie in 2..32");
   end

   src_cfg_t           cfg_q [NUM_SRC];
   logic [NUM_SRC-1:0] mask_q;
   logic               gmask_q;

   logic [NUM_SRC-1:0]             edge_mode, to_fast, req, elig;
   logic [NUM_SRC-1:0]             irq_cand, fiq_cand, ack_clr;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
   logic                           irq_pv, irq_hv, fiq_hv;
   logic [ID_W-1:0]                irq_pidx, irq_idx, fiq_idx;
   logic                           ack_irq, ack_fiq, cfg_hit;

   assign ack_irq = reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[0];
   assign ack_fiq = reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[1];
   assign cfg_hit = reg_addr_i[5] && (32'(reg_addr_i[4:0]) < NUM_SRC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         gmask_q <= 1'b1;
         for (int i = 0; i < NUM_SRC; i++) cfg_q[i] <= '0;
      end else if (reg_we_i) begin
         if (reg_addr_i == A_MASK)  mask_q  <= reg_wdata_i[NUM_SRC-1:0];
         if (reg_addr_i == A_GMASK) gmask_q <= reg_wdata_i[0];
         for (int i = 0; i < NUM_SRC; i++) begin
            if (cfg_hit && reg_addr_i[4:0] == 5'(i)) begin
               cfg_q[i].prio      <= reg_wdata_i[PRIO_W+1:2];
               cfg_q[i].edge_mode <= reg_wdata_i[1];
               cfg_q[i].to_fast   <= FIQ_EN & reg_wdata_i[0];
            end
         end
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cfg
      assign edge_mode[i] = cfg_q[i].edge_mode;
      assign to_fast[i]   = FIQ_EN & cfg_q[i].to_fast;
      assign prio[i]      = cfg_q[i].prio;
   end

   always_comb begin
      ack_clr = '0;
      if (ack_irq && irq_hv) ack_clr[irq_idx] = 1'b1;
      if (ack_fiq && fiq_hv) ack_clr[fiq_idx] = 1'b1;
   end

   intc_trig_capture #(.NUM_SRC(NUM_SRC)) u_trig (
      .clk, .rst_n, .src_i,
      .edge_mode_i  (edge_mode),
      .pend_wr_i    (reg_we_i && reg_addr_i == A_PEND),
      .pend_wdata_i (reg_wdata_i[NUM_SRC-1:0]),
      .ack_clr_i    (ack_clr),
      .req_o        (req)
   );

   assign elig     = req & ~mask_q;
   assign irq_cand = elig & ~to_fast;
   assign fiq_cand = elig & to_fast;

   intc_prio_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick_irq (
      .clk, .rst_n, .cand_i(irq_cand), .prio_i(prio),
      .valid_o(irq_pv), .idx_o(irq_pidx)
   );
   intc_out_hold #(.NUM_SRC(NUM_SRC)) u_hold_irq (
      .clk, .rst_n, .pick_v_i(irq_pv), .pick_idx_i(irq_pidx),
      .ack_i(ack_irq), .held_v_o(irq_hv), .held_idx_o(irq_idx)
   );

   if (FIQ_EN) begin : g_fast
      logic            fiq_pv;
      logic [ID_W-1:0] fiq_pidx;
      intc_prio_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick_fiq (
         .clk, .rst_n, .cand_i(fiq_cand), .prio_i(prio),
         .valid_o(fiq_pv), .idx_o(fiq_pidx)
      );
      intc_out_hold #(.NUM_SRC(NUM_SRC)) u_hold_fiq (
         .clk, .rst_n, .pick_v_i(fiq_pv), .pick_idx_i(fiq_pidx),
         .ack_i(ack_fiq), .held_v_o(fiq_hv), .held_idx_o(fiq_idx)
      );
   end else begin : g_no_fast
      logic unused_fast;
      assign unused_fast = ^fiq_cand;
      assign fiq_hv      = 1'b0;
      assign fiq_idx     = '0;
   end

   assign irq_o = irq_hv & ~gmask_q;
   assign fiq_o = fiq_hv & ~gmask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata_o <= '0;
      end else begin
         reg_rdata_o <= '0;
         if (cfg_hit) begin
            for (int i = 0; i < NUM_SRC; i++)
               if (reg_addr_i[4:0] == 5'(i)) reg_rdata_o <= 32'(cfg_q[i]);
         end else begin
            case (reg_addr_i)
               A_PEND:   reg_rdata_o <= 32'(req);
               A_MASK:   reg_rdata_o <= 32'(mask_q);
               A_GMASK:  reg_rdata_o <= 32'(gmask_q);
               A_SRCNUM: begin
                  reg_rdata_o[ID_W-1:0]   <= irq_idx;
                  reg_rdata_o[7]          <= irq_hv;
                  reg_rdata_o[8+:ID_W]    <= fiq_idx;
                  reg_rdata_o[15]         <= fiq_hv;
               end
               default:  reg_rdata_o <= '0;
            endcase
         end
      end
   end

   // R7
   ack_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_irq |=> !irq_o);
   // R7
   ack_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fiq |=> !fiq_o);
   // R10
   gmask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gmask_q && !reg_we_i) |=> !(irq_o || fiq_o));
endmodule

// File: tb/tb_intc_bank.sv
module tb_intc_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic [5:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, rdata2;
   logic        irq, fiq, irq2, fiq2;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2.5 clk = ~clk;

   intc_bank #(.NUM_SRC(32), .FIQ_EN(1'b1)) dut (
      .clk, .rst_n, .src_i(src), .reg_addr_i(addr), .reg_we_i(we),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq));
   intc_bank #(.NUM_SRC(32), .FIQ_EN(1'b0)) dut_lvl2 (
      .clk, .rst_n, .src_i(src), .reg_addr_i(addr), .reg_we_i(we),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata2), .irq_o(irq2), .fiq_o(fiq2));

   typedef struct packed {
      logic [31:0] pat;
      logic        v;
      logic [4:0]  id;
   } vec_t;
   // priorities are (13*i+5) mod 32
   localparam vec_t TBL [8] = '{
      '{32'h0000_0001, 1'b1, 5'd0},
      '{32'h8000_0000, 1'b1, 5'd31},
      '{32'h0000_0029, 1'b1, 5'd0},
      '{32'h8000_0084, 1'b1, 5'd7},
      '{32'h0842_1000, 1'b1, 5'd12},
      '{32'hFFFF_FFFF, 1'b1, 5'd7},
      '{32'h0000_0216, 1'b1, 5'd1},
      '{32'h0000_0000, 1'b0, 5'd0}
   };

   function automatic logic [31:0] prio_of(int i);
      return 32'((13 * i + 5) % 32);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; we = 1'b0;
      @(negedge clk);
      d = rdata;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 fiq", 32'(fiq), 0);
      rd(6'd1, d);  chk("R1 mask", d, 32'hFFFF_FFFF);
      rd(6'd4, d);  chk("R1 gmask", d, 1);
      rd(6'd37, d); chk("R1 cfg5", d, 0);
      rd(6'd2, d);  chk("R1 srcnum", d, 0);

      for (int i = 0; i < 32; i++) wr(6'(32 + i), prio_of(i) << 2);
      rd(6'd44, d); chk("R11 cfg12 readback", d, prio_of(12) << 2);

      // R10 global mask blocks outputs
      wr(6'd1, 32'hFFFF_FFFE);
      src = 32'h1;
      cyc(2);
      chk("R10 gmask set blocks", 32'(irq), 0);
      wr(6'd4, 0);
      chk("R10 gmask cleared", 32'(irq), 1);
      src = 0; wr(6'd3, 1);

      // R2 masked source
      src = 32'h2;
      cyc(2);
      chk("R2 masked stays low", 32'(irq), 0);
      wr(6'd1, 0);
      cyc(2);
      chk("R2 unmasked raises", 32'(irq), 1);
      src = 0; wr(6'd3, 1);
      rd(6'd1, d); chk("R11 mask readback", d, 0);

      // R5 priority table
      foreach (TBL[k]) begin
         src = TBL[k].pat;
         cyc(2);
         chk("R5 table irq", 32'(irq), 32'(TBL[k].v));
         rd(6'd2, d);
         chk("R5 table active", 32'(d[7]), 32'(TBL[k].v));
         if (TBL[k].v) chk("R5 table id", 32'(d[4:0]), 32'(TBL[k].id));
         src = 0; wr(6'd3, 1);
         cyc(1);
      end

      // R5 ties
      wr(6'd41, 0); wr(6'd52, 0);
      src = (32'h1 << 9) | (32'h1 << 20);
      cyc(2); rd(6'd2, d);
      chk("R5 tie 9 vs 20", 32'(d[4:0]), 9);
      src = 0; wr(6'd3, 1);
      src = (32'h1 << 9) | (32'h1 << 7);
      cyc(2); rd(6'd2, d);
      chk("R5 tie 7 vs 9", 32'(d[4:0]), 7);
      src = 0; wr(6'd3, 1);

      // R6 hold against later urgent source
      src = 32'h8000_0000;
      cyc(2);
      src = 32'h8000_0080;
      cyc(3); rd(6'd2, d);
      chk("R6 held id", 32'(d[4:0]), 31);
      src = 32'h0000_0080;
      wr(6'd3, 1);
      cyc(1); rd(6'd2, d);
      chk("R6 next winner", 32'(d[4:0]), 7);
      src = 0; wr(6'd3, 1);

      // R4 edge mode
      wr(6'd37, (prio_of(5) << 2) | 2);
      src = 32'h20;
      cyc(3);
      chk("R4 edge raises", 32'(irq), 1);
      wr(6'd3, 1);
      cyc(4);
      chk("R4 high line no re-raise", 32'(irq), 0);

      // R9 pending register
      src = 0; cyc(1); src = 32'h20; cyc(3);
      src = 0;
      rd(6'd0, d); chk("R9 pending bit", d, 32'h20);
      wr(6'd0, 0);
      rd(6'd0, d); chk("R9 pending cleared", d, 0);
      wr(6'd3, 1);
      cyc(2);
      chk("R9 nothing left", 32'(irq), 0);

      // R3 level mode
      src = 32'h8;
      cyc(2);
      wr(6'd3, 1);
      chk("R7 ack drops irq", 32'(irq), 0);
      cyc(1);
      chk("R3 level re-raises", 32'(irq), 1);
      src = 0; wr(6'd3, 1);
      cyc(2);
      chk("R3 low level stays low", 32'(irq), 0);

      // R8 fast routing
      wr(6'd42, (prio_of(10) << 2) | 1);
      rd(6'd42, d); chk("R8 cfg fast bit kept", d, (prio_of(10) << 2) | 1);
      src = 32'h400;
      cyc(2);
      chk("R8 fiq raised", 32'(fiq), 1);
      chk("R8 irq quiet", 32'(irq), 0);
      chk("R8 second level irq", 32'(irq2), 1);
      chk("R8 second level fiq", 32'(fiq2), 0);
      rd(6'd2, d);
      chk("R5 fast srcnum", d & 32'h9F00, 32'h8A00);
      src = 0;
      wr(6'd3, 1);
      chk("R7 irq ack leaves fiq", 32'(fiq), 1);
      wr(6'd3, 2);
      chk("R7 fiq ack", 32'(fiq), 0);

      // R7 both at once
      src = 32'h408;
      cyc(2);
      chk("R7 pre irq", 32'(irq), 1);
      chk("R7 pre fiq", 32'(fiq), 1);
      src = 0;
      wr(6'd3, 3);
      chk("R7 both irq", 32'(irq), 0);
      chk("R7 both fiq", 32'(fiq), 0);

      summary();
      $finish;
   end
endmodule